// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This unit executes the atomic memory instructions of a 64-bit packet-filter virtual machine. The core hands it one decoded instruction at a time as an opcode byte, a 32-bit immediate, a base address, a 16-bit displacement, the source register value and the current value of register zero. The unit then runs a locked read-modify-write on a single-port memory. It reads the target word, computes the new value, writes it back when needed and reports completion together with any register writeback.

The operation is selected by the immediate, not by the opcode. The opcode only says that this is an atomic store-from-register and whether it is 32-bit or 64-bit wide. Four arithmetic/logic updates are supported (add, or, and, xor), each of them with an optional fetch flag that returns the prior memory value to the source register. Two swap forms are supported as well. Exchange always stores the source register. Compare-exchange stores only when memory equals register zero, and it always returns the prior value to register zero. A lock output covers the whole read-to-write window so that a shared memory controller can keep other masters out.

Top module: `atomic_rmw_seq`

## Requirements
- R1: After reset, done, illegal, lock, mem_req, src_wb_en and r0_wb_en are all low.
- R2: Only opcode 0xC3 (32-bit) and opcode 0xDB (64-bit) are accepted. In opcode bits, [2:0]=3 selects store-from-register, [7:5]=6 selects atomic mode, and [4:3] is the size (0 = word, 3 = double word). Any other opcode completes with done and illegal high in the cycle after start, and with no memory request.
- R3: The legal immediates are 0x00 add, 0x40 or, 0x50 and and 0xA0 xor, each optionally with bit 0 set as the fetch flag, plus 0xE1 exchange and 0xF1 compare-exchange. Any other immediate, including one with nonzero bits above bit 7, is handled as in R2.
- R4: The memory address is base_addr plus the sign-extended 16-bit offset.
- R5: Add, or, and and xor store the result of memory combined with the source value. In 32-bit form only bits [31:0] of the word change and bits [63:32] keep their old value.
- R6: With the fetch flag set, src_wb_en pulses with done and src_wb_data holds the prior memory value, zero-extended from 32 bits in word form. With the flag clear, there is no source writeback.
- R7: Exchange (0xE1) stores the source value and returns the prior memory value through the source writeback.
- R8: Compare-exchange (0xF1) stores the source value only when memory equals r0_val (low 32 bits only in word form). It always pulses r0_wb_en with the zero-extended prior value and never writes the source register. On a mismatch no write request is issued.
- R9: Each legal operation issues exactly one read and then at most one write. Every request holds its address and direction until mem_ready. lock is high whenever a request is outstanding.
- R10: done is a single-cycle pulse. Writeback enables are only high together with done, and lock is low when done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 32 | Immediate carrying the operation select |
| base_addr | input | ADDR_W | Base address from the destination register |
| offset | input | 16 | Signed displacement |
| src_val | input | DATA_W | Source register value |
| r0_val | input | DATA_W | Register zero value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Current request completes this cycle |
| lock | output | 1 | Exclusive access held |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Rejected operation, with done |
| src_wb_en | output | 1 | Write src_wb_data to the source register |
| src_wb_data | output | DATA_W | Source register writeback value |
| r0_wb_en | output | 1 | Write r0_wb_data to register zero |
| r0_wb_data | output | DATA_W | Register zero writeback value |

## Verification
The hardest case to reach is a word-form compare-exchange whose low halves match while the upper halves of memory and register zero differ. If the compare were done on the full 64 bits, this case would take the mismatch path. The bench preloads memory and builds r0_val from the memory low half plus an unrelated upper half, and it alternates this with true mismatches. Memory latency is also rotated between zero and two wait cycles, so that the lock and the held request are seen across stalls.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_DONE
  } rmw_state_t;

  typedef enum logic [2:0] {
    K_ADD, K_OR, K_AND, K_XOR, K_SWAP, K_CAS
  } rmw_kind_t;

  localparam logic [2:0] CLS_STORE_REG = 3'b011;
  localparam logic [2:0] MODE_ATOMIC   = 3'b110;
  localparam logic [1:0] SZ_WORD       = 2'b00;
  localparam logic [1:0] SZ_DWORD      = 2'b11;
endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
  import atomic_rmw_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [7:0]       opcode,
  input  logic [IMM_W-1:0] imm,
  output logic             legal,
  output logic             wide,
  output logic             fetch,
  output rmw_kind_t        kind
);
  logic op_ok;
  logic imm_ok;
  logic [7:0] sel;

  assign sel   = imm[7:0];
  assign wide  = (opcode[4:3] == SZ_DWORD);
  assign op_ok = (opcode[2:0] == CLS_STORE_REG) && (opcode[7:5] == MODE_ATOMIC) &&
                 ((opcode[4:3] == SZ_WORD) || wide);
  assign fetch = sel[0];

  always_comb begin
    kind   = K_ADD;
    imm_ok = 1'b0;
    case (sel[7:4])
      4'h0: begin kind = K_ADD; imm_ok = (sel[3:1] == 3'b000); end
      4'h4: begin kind = K_OR;  imm_ok = (sel[3:1] == 3'b000); end
      4'h5: begin kind = K_AND; imm_ok = (sel[3:1] == 3'b000); end
      4'hA: begin kind = K_XOR; imm_ok = (sel[3:1] == 3'b000); end
      4'hE: begin kind = K_SWAP; imm_ok = (sel[3:0] == 4'h1); end
      4'hF: begin kind = K_CAS;  imm_ok = (sel[3:0] == 4'h1); end
      default: begin kind = K_ADD; imm_ok = 1'b0; end
    endcase
  end

  assign legal = op_ok && imm_ok && (imm[IMM_W-1:8] == '0);
endmodule

// File: rtl/atomic_rmw_compute.sv
module atomic_rmw_compute
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  rmw_kind_t         kind,
  input  logic              wide,
  input  logic              fetch,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] r0_val,
  output logic [DATA_W-1:0] mem_new,
  output logic [DATA_W-1:0] old_ext,
  output logic              do_write,
  output logic              src_en,
  output logic              r0_en
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] opa, opb, res;
  logic match;

  assign opa = wide ? old_val : {{HALF_W{1'b0}}, old_val[HALF_W-1:0]};
  assign opb = wide ? src_val : {{HALF_W{1'b0}}, src_val[HALF_W-1:0]};

  always_comb begin
    case (kind)
      K_ADD:   res = opa + opb;
      K_OR:    res = opa | opb;
      K_AND:   res = opa & opb;
      K_XOR:   res = opa ^ opb;
      default: res = opb;
    endcase
  end

  assign match   = wide ? (old_val == r0_val)
                        : (old_val[HALF_W-1:0] == r0_val[HALF_W-1:0]);
  assign mem_new = wide ? res : {old_val[DATA_W-1:HALF_W], res[HALF_W-1:0]};
  assign old_ext = opa;
  assign do_write = (kind != K_CAS) || match;
  assign src_en   = fetch && (kind != K_CAS);
  assign r0_en    = (kind == K_CAS);
endmodule

// File: rtl/atomic_rmw_seq.sv
module atomic_rmw_seq
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] r0_val,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              lock,
  output logic              done,
  output logic              illegal,
  output logic              src_wb_en,
  output logic [DATA_W-1:0] src_wb_data,
  output logic              r0_wb_en,
  output logic [DATA_W-1:0] r0_wb_data
);
  localparam int EXT_W = ADDR_W - OFF_W;

  rmw_state_t state;
  logic       dec_legal, dec_wide, dec_fetch;
  rmw_kind_t  dec_kind;
  rmw_kind_t  kind_q;
  logic       wide_q, fetch_q;
  logic [DATA_W-1:0] src_q, r0_q, old_q;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] c_new, c_old;
  logic c_write, c_src, c_r0;
  logic src_pend, r0_pend;

  assign eff_addr = base_addr + {{EXT_W{offset[OFF_W-1]}}, offset};

  atomic_rmw_decode #(.IMM_W(IMM_W)) u_dec (
    .opcode(opcode), .imm(imm), .legal(dec_legal),
    .wide(dec_wide), .fetch(dec_fetch), .kind(dec_kind)
  );

  atomic_rmw_compute #(.DATA_W(DATA_W)) u_alu (
    .kind(kind_q), .wide(wide_q), .fetch(fetch_q),
    .old_val(old_q), .src_val(src_q), .r0_val(r0_q),
    .mem_new(c_new), .old_ext(c_old), .do_write(c_write),
    .src_en(c_src), .r0_en(c_r0)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      kind_q      <= K_ADD;
      wide_q      <= 1'b0;
      fetch_q     <= 1'b0;
      src_q       <= '0;
      r0_q        <= '0;
      old_q       <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      lock        <= 1'b0;
      done        <= 1'b0;
      illegal     <= 1'b0;
      src_wb_en   <= 1'b0;
      r0_wb_en    <= 1'b0;
      src_wb_data <= '0;
      r0_wb_data  <= '0;
      src_pend    <= 1'b0;
      r0_pend     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            kind_q  <= dec_kind;
            wide_q  <= dec_wide;
            fetch_q <= dec_fetch;
            src_q   <= src_val;
            r0_q    <= r0_val;
            if (dec_legal) begin
              mem_addr <= eff_addr;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              lock     <= 1'b1;
              state    <= ST_READ;
            end else begin
              done    <= 1'b1;
              illegal <= 1'b1;
              state   <= ST_DONE;
            end
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            old_q   <= mem_rdata;
            mem_req <= 1'b0;
            state   <= ST_CALC;
          end
        end
        ST_CALC: begin
          src_wb_data <= c_old;
          r0_wb_data  <= c_old;
          src_pend    <= c_src;
          r0_pend     <= c_r0;
          if (c_write) begin
            mem_wdata <= c_new;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            state     <= ST_WRITE;
          end else begin
            lock      <= 1'b0;
            done      <= 1'b1;
            src_wb_en <= c_src;
            r0_wb_en  <= c_r0;
            state     <= ST_DONE;
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            lock      <= 1'b0;
            done      <= 1'b1;
            src_wb_en <= src_pend;
            r0_wb_en  <= r0_pend;
            state     <= ST_DONE;
          end
        end
        default: begin
          done      <= 1'b0;
          illegal   <= 1'b0;
          src_wb_en <= 1'b0;
          r0_wb_en  <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/atomic_rmw_seq_chk.sv
module atomic_rmw_seq_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              illegal,
  input logic              lock,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              src_wb_en,
  input logic              r0_wb_en
);
  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> lock); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    done |-> (!lock && !mem_req)); // R10
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (src_wb_en || r0_wb_en) |-> done); // R10
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !src_wb_en && !r0_wb_en)); // R2
  AST_CAS_R0_ONLY: assert property (@(posedge clk) disable iff (rst)
    r0_wb_en |-> !src_wb_en); // R8
endmodule

bind atomic_rmw_seq atomic_rmw_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/atomic_rmw_seq_test.sv
module atomic_rmw_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [31:0] imm = '0;
  logic [63:0] base_addr = '0;
  logic [15:0] offset = '0;
  logic [63:0] src_val = '0, r0_val = '0;
  logic        mem_req, mem_we, mem_ready, lock, done, illegal;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        src_wb_en, r0_wb_en;
  logic [63:0] src_wb_data, r0_wb_data;

  atomic_rmw_seq uut (.*);

  logic [63:0] mem [16];
  int lat = 0;
  int wcnt = 0;
  int n_rd = 0, n_wr = 0, order_err = 0, unlocked = 0;
  logic [63:0] rd_addr;
  int checks = 0, fails = 0, cyc = 0;

  assign mem_ready = mem_req && (wcnt == lat);
  assign mem_rdata = mem[mem_addr[6:3]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !lock) unlocked <= unlocked + 1;
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[6:3]] <= mem_wdata;
        n_wr <= n_wr + 1;
        if (n_rd == 0) order_err <= order_err + 1;
      end else begin
        n_rd <= n_rd + 1;
        rd_addr <= mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic        got_done, got_ill, got_sen, got_ren, dbl_done;
  logic [63:0] got_sd, got_rd;

  task automatic run_op(input logic [7:0] opc, input logic [31:0] im, input logic [63:0] b,
                        input logic [15:0] off, input logic [63:0] s, input logic [63:0] r);
    int t;
    @(negedge clk);
    n_rd = 0; n_wr = 0; order_err = 0; unlocked = 0;
    opcode = opc; imm = im; base_addr = b; offset = off; src_val = s; r0_val = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 50) begin
      @(negedge clk);
      t++;
    end
    got_done = done; got_ill = illegal; got_sen = src_wb_en; got_ren = r0_wb_en;
    got_sd = src_wb_data; got_rd = r0_wb_data;
    @(negedge clk);
    dbl_done = done;
  endtask

  initial begin
    logic [63:0] m0, s0, r0v, e_mem, e_old, res, a, bb, addr;
    logic e_wr, e_sen, e_ren, wide, match;
    logic [7:0] sel;
    logic [7:0] ops [10];
    ops[0] = 8'h00; ops[1] = 8'h01; ops[2] = 8'h40; ops[3] = 8'h41; ops[4] = 8'h50;
    ops[5] = 8'h51; ops[6] = 8'hA0; ops[7] = 8'hA1; ops[8] = 8'hE1; ops[9] = 8'hF1;
    for (int i = 0; i < 16; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !illegal && !lock && !mem_req && !src_wb_en && !r0_wb_en, "R1 reset outputs",
        {58'b0, done, illegal, lock, mem_req, src_wb_en, r0_wb_en}, 64'h0);
    rst = 1'b0;

    // Legal operation sweep: every immediate, both widths, four data patterns
    for (int oi = 0; oi < 10; oi++) begin
      for (int w = 0; w < 2; w++) begin
        for (int p = 0; p < 4; p++) begin
          sel  = ops[oi];
          wide = (w == 1);
          lat  = (oi + p) % 3;
          m0  = 64'hF0E1_D2C3_B4A5_9687 ^ (64'h1357_9BDF_2468_ACE1 * (p + 1));
          s0  = 64'h8000_0001_FFFF_FFF0 + 64'h0101_0101_0101_0101 * (p + oi);
          r0v = (p % 2 == 0) ? {~m0[63:32] ^ {28'b0, 4'(w)}, m0[31:0]} : m0 + 64'd5;
          if (wide && p % 2 == 0) r0v = m0;
          mem[p + 4] = m0;
          // base + negative offset lands on word p+4 (R4)
          addr = 64'h0000_0000_0000_2000 + 64'(p + 4) * 8;
          a  = wide ? m0 : {32'b0, m0[31:0]};
          bb = wide ? s0 : {32'b0, s0[31:0]};
          case (sel[7:4])
            4'h0: res = a + bb;
            4'h4: res = a | bb;
            4'h5: res = a & bb;
            4'hA: res = a ^ bb;
            default: res = bb;
          endcase
          match = wide ? (m0 == r0v) : (m0[31:0] == r0v[31:0]);
          e_wr  = (sel != 8'hF1) || match;
          e_mem = !e_wr ? m0 : (wide ? res : {m0[63:32], res[31:0]});
          e_old = a;
          e_sen = sel[0] && (sel != 8'hF1);
          e_ren = (sel == 8'hF1);
          run_op(wide ? 8'hDB : 8'hC3, {24'b0, sel}, addr + 64'h100, 16'hFF00, s0, r0v);
          chk(got_done && !got_ill, "R10 legal op completes", {62'b0, got_done, got_ill}, 64'h2);
          chk(!dbl_done, "R10 done single pulse", {63'b0, dbl_done}, 64'h0);
          chk(rd_addr == addr, "R4 effective address", rd_addr, addr);
          if (sel == 8'hE1) chk(mem[p + 4] == e_mem, "R7 exchange memory", mem[p + 4], e_mem);
          else if (sel == 8'hF1) chk(mem[p + 4] == e_mem, "R8 compare-exchange memory", mem[p + 4], e_mem);
          else chk(mem[p + 4] == e_mem, "R5 updated memory", mem[p + 4], e_mem);
          chk(got_sen == e_sen, "R6 source writeback enable", {63'b0, got_sen}, {63'b0, e_sen});
          if (e_sen) chk(got_sd == e_old, "R6 fetched value", got_sd, e_old);
          chk(got_ren == e_ren, "R8 r0 writeback enable", {63'b0, got_ren}, {63'b0, e_ren});
          if (e_ren) chk(got_rd == e_old, "R8 r0 old value", got_rd, e_old);
          chk(n_rd == 1 && n_wr == (e_wr ? 1 : 0), "R9 access count",
              64'(n_rd * 16 + n_wr), 64'(16 + (e_wr ? 1 : 0)));
          chk(order_err == 0 && unlocked == 0, "R9 read first under lock",
              64'(order_err + unlocked), 64'h0);
        end
      end
    end

    // Opcode sweep with a legal immediate
    for (int o = 0; o < 256; o++) begin
      logic exp_ill;
      exp_ill = !(o == 8'hC3 || o == 8'hDB);
      lat = o % 3;
      run_op(8'(o), 32'h0, 64'h2000, 16'h0040, 64'h1, 64'h0);
      chk(got_done && got_ill == exp_ill, "R2 opcode acceptance", {63'b0, got_ill}, {63'b0, exp_ill});
      if (exp_ill) chk(n_rd == 0 && n_wr == 0 && !got_sen && !got_ren, "R2 no access when illegal",
                       64'(n_rd + n_wr), 64'h0);
    end

    // Immediate sweep, including nonzero upper bits
    for (int v = 0; v < 260; v++) begin
      logic exp_ill;
      logic [31:0] iv;
      iv = (v < 256) ? 32'(v) : (32'h100 << (v - 256)) | 32'h40;
      sel = iv[7:0];
      exp_ill = 1'b1;
      if (iv[31:8] == 24'h0) begin
        if ((sel[7:1] == 7'h00) || (sel[7:1] == 7'h20) || (sel[7:1] == 7'h28) ||
            (sel[7:1] == 7'h50) || (sel == 8'hE1) || (sel == 8'hF1)) exp_ill = 1'b0;
      end
      lat = v % 2;
      run_op(8'hDB, iv, 64'h2000, 16'h0048, 64'h3, 64'h0);
      chk(got_done && got_ill == exp_ill, "R3 immediate acceptance", {32'b0, iv}, {63'b0, exp_ill});
      if (exp_ill) chk(n_rd == 0 && n_wr == 0, "R3 no access when illegal", 64'(n_rd + n_wr), 64'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule